// File: doc/BRIEF.md
# Split-Gate Exposure Pulse Sequencer

This block drives the split-gate control line of a dual-store pixel during one exposure. Photo-charge is steered to a low-sensitivity store while the gate is high, and to a high-sensitivity store while it is low. One exposure holds a programmed number of short high phases. Between each pair of neighbouring high phases there is a long low phase, so the two stores integrate over nearly the same stretch of time and a moving scene blurs alike in both. An optional low segment can close the exposure, which lets the overall high-to-low time ratio be trimmed.

All lengths are counted in clock ticks. Software sets four values: the on-length, an integer off-to-on ratio, the cycle count and the trailing length. A one-cycle start pulse launches the exposure. The block captures all settings on the accepted start, multiplies the ratio by the on-length once, and runs every phase from a single down-counter. For the whole exposure it raises an active flag and a transfer-gate hold flag. It ends with a one-cycle done pulse.

Top module: `split_gate_seq`

## Requirements
- R1: While reset is asserted and after its release with no start, gate_o, active_o, tx_hold_o and done_o are all 0.
- R2: An accepted start with nonzero on-length and cycle count raises gate_o and active_o in the next cycle. Each high phase of gate_o lasts exactly on_ticks_i cycles.
- R3: Each low phase between two high phases lasts ratio_i × on_ticks_i cycles, with active_o held at 1. A ratio of 0 is treated as 1. Ratios 7, 30, 111 and 279 work with the default widths.
- R4: One exposure contains exactly cycles_i high phases of gate_o and cycles_i − 1 low phases between them. Low-sensitivity time is therefore cycles_i × on_ticks_i cycles.
- R5: After the last high phase, gate_o stays 0 while active_o stays 1 for tail_ticks_i cycles. A tail of 0 ends the exposure straight after the last high phase.
- R6: done_o is high for exactly one cycle. That cycle follows the last cycle with active_o high, and active_o and gate_o are 0 during it. With T total active cycles, done_o appears T+1 cycles after the start edge.
- R7: tx_hold_o equals active_o in every cycle, and gate_o is never 1 while active_o is 0.
- R8: A start is accepted only when neither active_o nor done_o is high. A start at any other time has no effect on the running exposure's waveform or length.
- R9: A start with on_ticks_i = 0 or cycles_i = 0 produces done_o in the next cycle. gate_o and active_o stay 0.
- R10: The settings are captured on the accepted start. Changing them during the exposure does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| on_ticks_i | input | ON_W (16) | High-phase length in ticks |
| ratio_i | input | RATIO_W (9) | Off-to-on ratio, 0 treated as 1 |
| cycles_i | input | CYC_W (8) | Number of high phases |
| tail_ticks_i | input | TAIL_W (24) | Trailing low segment length in ticks |
| gate_o | output | 1 | Split-gate level, high steers charge to the low-sensitivity store |
| active_o | output | 1 | Exposure in progress |
| tx_hold_o | output | 1 | Hold transfer gate at its blocking level |
| done_o | output | 1 | One-cycle end-of-exposure pulse |

## Verification
A wrong phase length or a stale product in the shared counter shows at the ports within that phase. gate_o then falls or rises a cycle early or late, so the per-phase high and low counts miss at the first affected phase. A wrong cycle counter shows up as an extra or missing gate pulse and a shifted done_o, visible once the exposure ends. Errors in start acceptance or in capturing the settings change the total active time, and a start issued mid-run or in the done cycle exposes them within one exposure.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ON   = 3'd1,
    ST_OFF  = 3'd2,
    ST_TAIL = 3'd3,
    ST_DONE = 3'd4
  } sgs_state_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sgs_len_regs.sv
module sgs_len_regs #(
  parameter int unsigned ON_W    = 16,
  parameter int unsigned RATIO_W = 9,
  parameter int unsigned TAIL_W  = 24,
  localparam int unsigned OFF_W  = ON_W + RATIO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ON_W-1:0]    on_ticks_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [TAIL_W-1:0]  tail_ticks_i,
  output logic [ON_W-1:0]    on_len_o,
  output logic [OFF_W-1:0]   off_len_o,
  output logic [TAIL_W-1:0]  tail_len_o
);
  logic [RATIO_W-1:0] ratio_eff;
  logic [OFF_W-1:0]   off_prod;

  // zero ratio behaves as unity
  assign ratio_eff = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
  assign off_prod  = OFF_W'(on_ticks_i) * OFF_W'(ratio_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_len_o   <= '0;
      off_len_o  <= '0;
      tail_len_o <= '0;
    end else if (load_i) begin
      on_len_o   <= on_ticks_i;
      off_len_o  <= off_prod;
      tail_len_o <= tail_ticks_i;
    end
  end

  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(off_len_o) && $stable(on_len_o) && $stable(tail_len_o)); // R10
endmodule

// File: rtl/sgs_phase_timer.sv
module sgs_phase_timer #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == '0);

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
  import sgs_pkg::*;
#(
  parameter int unsigned ON_W   = 16,
  parameter int unsigned OFF_W  = 25,
  parameter int unsigned CYC_W  = 8,
  parameter int unsigned TAIL_W = 24,
  parameter int unsigned CNT_W  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ON_W-1:0]   on_ticks_i,
  input  logic [CYC_W-1:0]  cycles_i,
  input  logic [ON_W-1:0]   on_len_i,
  input  logic [OFF_W-1:0]  off_len_i,
  input  logic [TAIL_W-1:0] tail_len_i,
  input  logic              expire_i,
  output logic              accept_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              gate_o,
  output logic              active_o,
  output logic              done_o
);
  sgs_state_e       state_q, state_d;
  logic [CYC_W-1:0] cyc_left_q, cyc_left_d;
  logic             zero_req;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign zero_req = (on_ticks_i == '0) || (cycles_i == '0);

  always_comb begin
    state_d    = state_q;
    cyc_left_d = cyc_left_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        if (zero_req) begin
          state_d = ST_DONE;
        end else begin
          state_d    = ST_ON;
          cyc_left_d = cycles_i;
          load_o     = 1'b1;
          load_val_o = CNT_W'(on_ticks_i) - CNT_W'(1);
        end
      end
      ST_ON: if (expire_i) begin
        cyc_left_d = cyc_left_q - CYC_W'(1);
        if (cyc_left_q == CYC_W'(1)) begin
          if (tail_len_i != '0) begin
            state_d    = ST_TAIL;
            load_o     = 1'b1;
            load_val_o = CNT_W'(tail_len_i) - CNT_W'(1);
          end else begin
            state_d = ST_DONE;
          end
        end else begin
          state_d    = ST_OFF;
          load_o     = 1'b1;
          load_val_o = CNT_W'(off_len_i) - CNT_W'(1);
        end
      end
      ST_OFF: if (expire_i) begin
        state_d    = ST_ON;
        load_o     = 1'b1;
        load_val_o = CNT_W'(on_len_i) - CNT_W'(1);
      end
      ST_TAIL: if (expire_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cyc_left_q <= '0;
    end else begin
      state_q    <= state_d;
      cyc_left_q <= cyc_left_d;
    end
  end

  assign gate_o   = (state_q == ST_ON);
  assign active_o = (state_q == ST_ON) || (state_q == ST_OFF) || (state_q == ST_TAIL);
  assign done_o   = (state_q == ST_DONE);

  // checker-side run counters
  logic             gate_d_q;
  logic [CNT_W-1:0] hi_run_q, lo_run_q;
  logic [CYC_W-1:0] pulses_q, cyc_tot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_d_q  <= 1'b0;
      hi_run_q  <= '0;
      lo_run_q  <= '0;
      pulses_q  <= '0;
      cyc_tot_q <= '0;
    end else begin
      gate_d_q <= gate_o;
      hi_run_q <= gate_o ? hi_run_q + CNT_W'(1) : '0;
      lo_run_q <= (active_o && !gate_o) ? lo_run_q + CNT_W'(1) : '0;
      if (accept_o) begin
        pulses_q  <= '0;
        cyc_tot_q <= cycles_i;
      end else if (gate_o && !gate_d_q) begin
        pulses_q <= pulses_q + CYC_W'(1);
      end
    end
  end

  AST_FIRST_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> gate_o); // R2
  AST_ON_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |-> (hi_run_q == CNT_W'(on_len_i))); // R2
  AST_OFF_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o) && pulses_q != '0) |-> (lo_run_q == CNT_W'(off_len_i))); // R3
  AST_PULSE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(active_o)) |-> (pulses_q == cyc_tot_q)); // R4
  AST_TAIL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(active_o)) |-> (lo_run_q == CNT_W'(tail_len_i))); // R5
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_GATE_IN_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> active_o); // R7
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (active_o || done_o)) |=> !$rose(active_o)); // R8
  AST_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && zero_req) |=> (done_o && !active_o && !gate_o)); // R9
endmodule

// File: rtl/split_gate_seq.sv
module split_gate_seq
  import sgs_pkg::*;
#(
  parameter int unsigned ON_W    = 16,
  parameter int unsigned RATIO_W = 9,
  parameter int unsigned CYC_W   = 8,
  parameter int unsigned TAIL_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ON_W-1:0]    on_ticks_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [CYC_W-1:0]   cycles_i,
  input  logic [TAIL_W-1:0]  tail_ticks_i,
  output logic               gate_o,
  output logic               active_o,
  output logic               tx_hold_o,
  output logic               done_o
);
  localparam int unsigned OFF_W = ON_W + RATIO_W;
  localparam int unsigned CNT_W = imax(OFF_W, TAIL_W);

  logic              accept, load, expire;
  logic [CNT_W-1:0]  load_val;
  logic [ON_W-1:0]   on_len;
  logic [OFF_W-1:0]  off_len;
  logic [TAIL_W-1:0] tail_len;

  sgs_len_regs #(
    .ON_W(ON_W), .RATIO_W(RATIO_W), .TAIL_W(TAIL_W)
  ) u_len (
    .clk_i, .rst_ni,
    .load_i       (accept),
    .on_ticks_i, .ratio_i, .tail_ticks_i,
    .on_len_o     (on_len),
    .off_len_o    (off_len),
    .tail_len_o   (tail_len)
  );

  sgs_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  sgs_ctrl #(
    .ON_W(ON_W), .OFF_W(OFF_W), .CYC_W(CYC_W), .TAIL_W(TAIL_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .on_ticks_i, .cycles_i,
    .on_len_i   (on_len),
    .off_len_i  (off_len),
    .tail_len_i (tail_len),
    .expire_i   (expire),
    .accept_o   (accept),
    .load_o     (load),
    .load_val_o (load_val),
    .gate_o, .active_o, .done_o
  );

  assign tx_hold_o = active_o;

  AST_HOLD_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_hold_o == active_o) && !(done_o && active_o)); // R7
endmodule

// File: tb/split_gate_seq_bench.sv
module split_gate_seq_bench;
  localparam int NV = 9;
  localparam int V_ON   [NV] = '{3, 2,   1,   1, 4, 0, 5, 2, 1};
  localparam int V_RAT  [NV] = '{7, 30, 111, 279, 0, 7, 7, 3, 1};
  localparam int V_CYC  [NV] = '{4, 3,   2,   2, 3, 3, 0, 1, 5};
  localparam int V_TAIL [NV] = '{5, 0,  10,   0, 2, 4, 4, 6, 0};

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] on_t = '0;
  logic [8:0]  ratio = '0;
  logic [7:0]  cyc = '0;
  logic [23:0] tail = '0;
  logic        gate, active, hold, done;
  int n_chk = 0, n_bad = 0, wd = 0;

  always #10 clk = ~clk;

  split_gate_seq u_split_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .on_ticks_i(on_t), .ratio_i(ratio), .cycles_i(cyc), .tail_ticks_i(tail),
    .gate_o(gate), .active_o(active), .tx_hold_o(hold), .done_o(done)
  );

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // runs one exposure; inj>0 issues a second start with other settings at that cycle
  task automatic run_seq(input int o, input int r, input int c, input int t, input int inj);
    int re, hi_e, lo_e, tot_e, ris_e;
    int hi, lo, ris, k, bad_hold;
    logic prev;
    re    = (r == 0) ? 1 : r;
    hi_e  = (o == 0 || c == 0) ? 0 : c * o;
    lo_e  = (o == 0 || c == 0) ? 0 : (c - 1) * o * re + t;
    ris_e = (o == 0 || c == 0) ? 0 : c;
    tot_e = hi_e + lo_e;
    @(negedge clk);
    on_t = 16'(o); ratio = 9'(r); cyc = 8'(c); tail = 24'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hi = 0; lo = 0; ris = 0; k = 1; bad_hold = 0; prev = 1'b0;
    while (!done && k < 5000) begin
      if (gate) hi++;
      if (active && !gate) lo++;
      if (gate && !prev) ris++;
      if (hold != active || (gate && !active)) bad_hold++;
      prev = gate;
      if (inj > 0 && k == inj) begin
        start = 1'b1; on_t = 16'd9; ratio = 9'd2; cyc = 8'd6; tail = 24'd1;
      end else if (inj > 0 && k == inj + 1) begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R2 high cycles", hi, hi_e);
    check("R3 R5 low active cycles", lo, lo_e);
    check("R4 gate pulses", ris, ris_e);
    check("R6 start-to-done latency", k, tot_e + 1);
    check("R7 hold/gate vs active", bad_hold, 0);
    check("R6 outputs idle in done cycle", {30'd0, active, gate}, 0);
    // R8: a start during the done cycle is ignored
    on_t = 16'd2; cyc = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 R8 done one cycle, no restart", {30'd0, done, active}, 0);
  endtask

  initial begin
    #5;
    check("R1 reset outputs", {28'd0, gate, active, hold, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {28'd0, gate, active, hold, done}, 0);

    for (int i = 0; i < NV; i++)
      run_seq(V_ON[i], V_RAT[i], V_CYC[i], V_TAIL[i], 0);

    // R8 R10: mid-run start with new settings must not change the exposure
    run_seq(3, 7, 2, 4, 5);
    run_seq(2, 5, 3, 3, 12);

    // R9: zero cycles, gate never rises
    run_seq(6, 30, 0, 0, 0);

    // R1: reset during an exposure returns outputs low
    @(negedge clk);
    on_t = 16'd10; ratio = 9'd7; cyc = 8'd5; tail = 24'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 gate high mid-phase", {31'd0, gate}, 1);
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-run", {28'd0, gate, active, hold, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 stays idle after reset", {28'd0, gate, active, hold, done}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule